// File: doc/BRIEF.md
# Segmented Address Translation and Protection Unit

This block turns a segment-relative memory access into a linear address. Each request carries an access kind, a 32-bit offset and the current ring of the requester. The kind picks one of six segment registers by default, and an override can name a register directly. The 16-bit selector held in that register chooses a descriptor from one of two on-chip descriptor tables, a global one and a local one. One combinational lookup then checks three things: the selector is not null, the offset is within the segment limit, and both the segment type and the rings allow the access. The result is the descriptor base plus the offset, or a two-bit fault code.

Descriptors are written through a plain write port, which only ring 0 may use. Segment registers are loaded through a second plain port. Requests and responses use valid/ready handshakes. A request is accepted on a rising edge when `req_valid` and `req_ready` are both high. Its response shows on `rsp_valid` from the next cycle and is consumed on an edge where `rsp_ready` is high. `req_ready` falls only while an unconsumed response waits, so back-pressure on the response side stalls the request side with no loss. While it waits, the response does not change.

Top module: `seg_xlate_top`

## Requirements
- R1: A selector has three fields. Bits [15:3] hold the table index, bit 2 picks the table (0 global, 1 local) and bits [1:0] hold the requester ring. A selector with bit 2 at 0 and index 0 is null, and any access through it gives fault code 1. Local index 0 is an ordinary entry.
- R2: With `req_ovr_en` low, the access kind picks the segment register. Kind 0 (fetch) uses register 0 (code). Kinds 1 (read) and 2 (write) use register 1 (data). Kinds 3 (pop) and 4 (push) use register 2 (stack). With `req_ovr_en` high, `req_ovr_seg` picks register 0 to 5, and the values 6 and 7 pick register 1. Kinds 5 to 7 behave as read.
- R3: With no fault, `rsp_lin` is base + offset modulo 2^32 and `rsp_fault` is 0. A descriptor with base 0 and limit 0xFFFFFFFF passes every offset through unchanged.
- R4: Fault code 2 (limit) is given when the offset is greater than the descriptor limit. It is also given when the index is not below the table depth, which is 16 for the global table and 8 for the local table by default.
- R5: Type check. A code descriptor allows fetch; it allows read and pop only when its rw flag is set; it never allows write or push. A data descriptor never allows fetch; it always allows read and pop; it allows write and push only when its rw flag is set. A disallowed kind gives fault code 3.
- R6: Ring check. For every kind except fetch, the access gives fault code 3 when `req_cpl` or the selector ring is numerically greater than the descriptor ring. Fetches are not ring-checked.
- R7: Fault priority is null (1), then limit (2), then type/ring (3). Whenever `rsp_fault` is not 0, `rsp_lin` is 0.
- R8: A descriptor write with `dw_ring` equal to 0 stores the base, limit, code flag, rw flag and ring into the chosen entry. With any other ring the write is ignored and `dw_fault` is high in the following cycle only. A write whose index is beyond the table depth is ignored.
- R9: The response appears in the cycle after acceptance. `req_ready` is high exactly when no response is waiting or `rsp_ready` is high. A waiting response holds its fault and address stable until it is consumed.
- R10: After reset, `rsp_valid` and `dw_fault` are 0, every segment register holds 0 and every descriptor is all zero.
- R11: `sr_we` loads `sr_val` into segment register `sr_num` on the next edge. A write with `sr_num` of 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_valid | input | 1 | Descriptor write strobe |
| dw_ring | input | 2 | Ring of the writer; only 0 may write |
| dw_local | input | 1 | Write target table: 0 global, 1 local |
| dw_index | input | 13 | Entry index to write |
| dw_base | input | 32 | Descriptor base linear address |
| dw_limit | input | 32 | Largest valid offset |
| dw_code | input | 1 | 1 code segment, 0 data segment |
| dw_rw | input | 1 | Code: readable; data: writable |
| dw_dpl | input | 2 | Descriptor ring |
| dw_fault | output | 1 | Rejected descriptor write, one cycle |
| sr_we | input | 1 | Segment register write strobe |
| sr_num | input | 3 | Segment register number 0..5 |
| sr_val | input | 16 | Selector value to load |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_kind | input | 3 | 0 fetch, 1 read, 2 write, 3 pop, 4 push |
| req_ovr_en | input | 1 | Use req_ovr_seg instead of the default register |
| req_ovr_seg | input | 3 | Explicit segment register number |
| req_offset | input | 32 | Offset within the segment |
| req_cpl | input | 2 | Current ring of the requester |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with valid |
| rsp_fault | output | 2 | 0 none, 1 null, 2 limit, 3 type/ring |
| rsp_lin | output | 32 | Linear address, 0 on fault |

## Verification
Assertions check several things on every cycle. A waiting response stays frozen under back-pressure. A faulting response carries a zero address. An accepted fault-free access never has an offset above its limit. A null global selector always resolves to fault 1. Each segment register and table entry takes exactly the value written. A table entry stays unchanged when a write comes from a non-zero ring. Other behaviour shows only in the bench scenarios, where results are compared with an independent model. That covers the choice of default segment, the base-plus-offset arithmetic, the full type and ring matrix with selector-ring effects, fault priority between limit and type, out-of-range indices, and the order of two requests held in a stall.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int ADDR_W    = 32;
  localparam int SEL_W     = 16;
  localparam int IDX_W     = 13;
  localparam int RING_W    = 2;
  localparam int NUM_SEGS  = 6;
  localparam int SEGN_W    = 3;
  localparam int SEG_CODE  = 0;
  localparam int SEG_DATA  = 1;
  localparam int SEG_STACK = 2;

  typedef enum logic [2:0] {
    ACC_FETCH = 3'd0,
    ACC_READ  = 3'd1,
    ACC_WRITE = 3'd2,
    ACC_POP   = 3'd3,
    ACC_PUSH  = 3'd4
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NULL  = 2'd1,
    FLT_LIMIT = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic              is_code;
    logic              rw;
    logic [RING_W-1:0] dpl;
  } desc_t;
endpackage

// File: rtl/seg_selreg_file.sv
module seg_selreg_file
  import segx_pkg::*;
#(
  parameter int NUM = NUM_SEGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEGN_W-1:0] wnum,
  input  logic [SEL_W-1:0]  wval,
  input  logic [SEGN_W-1:0] rnum,
  output logic [SEL_W-1:0]  rsel
);
  logic [SEL_W-1:0] sel_q [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) sel_q[i] <= '0;
      else if (we && wnum == SEGN_W'(i)) sel_q[i] <= wval;
    end

    assert_selreg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wnum == SEGN_W'(i)) |=> (sel_q[i] == $past(wval)));

    assert_selreg_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!we || wnum != SEGN_W'(i)) |=> $stable(sel_q[i]));
  end

  // Numbers beyond the file fall back to the data register.
  always_comb begin
    rsel = sel_q[SEG_DATA];
    for (int i = 0; i < NUM; i++)
      if (rnum == SEGN_W'(i)) rsel = sel_q[i];
  end
endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import segx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [RING_W-1:0] wr_ring,
  input  logic [IDX_W-1:0]  wr_idx,
  input  desc_t             wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output desc_t             rd_data,
  output logic              rd_hit
);
  desc_t ent_q [DEPTH];
  logic  wr_allow;

  assign wr_allow = wr_req && (wr_ring == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (wr_allow && wr_idx == IDX_W'(i)) ent_q[i] <= wr_data;
    end

    assert_blocked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ring != '0 && wr_idx == IDX_W'(i)) |=> $stable(ent_q[i]));

    assert_ring0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ring == '0 && wr_idx == IDX_W'(i)) |=> (ent_q[i] == $past(wr_data)));
  end

  assign rd_hit = (rd_idx < IDX_W'(DEPTH));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IDX_W'(i)) rd_data = ent_q[i];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import segx_pkg::*;
(
  input  logic [2:0]        kind,
  input  logic [SEL_W-1:0]  sel,
  input  desc_t             desc,
  input  logic              hit,
  input  logic [ADDR_W-1:0] offset,
  input  logic [RING_W-1:0] cpl,
  output fault_e            fault,
  output logic [ADDR_W-1:0] lin
);
  logic is_null, over, type_bad, ring_bad;
  logic k_fetch, k_store;
  logic [RING_W-1:0] rpl;

  assign rpl     = sel[RING_W-1:0];
  assign is_null = !sel[RING_W] && (sel[SEL_W-1:RING_W+1] == '0);
  assign over    = !hit || (offset > desc.limit);
  assign k_fetch = (kind == ACC_FETCH);
  assign k_store = (kind == ACC_WRITE) || (kind == ACC_PUSH);

  always_comb begin
    if (desc.is_code) type_bad = k_store || (!k_fetch && !desc.rw);
    else              type_bad = k_fetch || (k_store && !desc.rw);
  end

  assign ring_bad = !k_fetch && ((cpl > desc.dpl) || (rpl > desc.dpl));

  always_comb begin
    if (is_null)                   fault = FLT_NULL;
    else if (over)                 fault = FLT_LIMIT;
    else if (type_bad || ring_bad) fault = FLT_PROT;
    else                           fault = FLT_NONE;
  end

  assign lin = (fault == FLT_NONE) ? (desc.base + offset) : '0;
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import segx_pkg::*;
#(
  parameter int G_DEPTH = 16,
  parameter int L_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dw_valid,
  input  logic [1:0]           dw_ring,
  input  logic                 dw_local,
  input  logic [12:0]          dw_index,
  input  logic [31:0]          dw_base,
  input  logic [31:0]          dw_limit,
  input  logic                 dw_code,
  input  logic                 dw_rw,
  input  logic [1:0]           dw_dpl,
  output logic                 dw_fault,
  input  logic                 sr_we,
  input  logic [2:0]           sr_num,
  input  logic [15:0]          sr_val,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_kind,
  input  logic                 req_ovr_en,
  input  logic [2:0]           req_ovr_seg,
  input  logic [31:0]          req_offset,
  input  logic [1:0]           req_cpl,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_fault,
  output logic [31:0]          rsp_lin
);
  localparam int NTAB = 2;

  desc_t             wr_desc;
  desc_t             tab_rd  [NTAB];
  logic              tab_hit [NTAB];
  logic [SEGN_W-1:0] seg_num;
  logic [SEL_W-1:0]  cur_sel;
  logic [IDX_W-1:0]  cur_idx;
  desc_t             cur_desc;
  logic              cur_hit;
  fault_e            chk_fault;
  logic [ADDR_W-1:0] chk_lin;
  logic              accept;

  assign wr_desc = '{base: dw_base, limit: dw_limit, is_code: dw_code,
                     rw: dw_rw, dpl: dw_dpl};

  // Default segment by access kind, unless overridden.
  always_comb begin
    if (req_ovr_en) seg_num = req_ovr_seg;
    else begin
      case (req_kind)
        ACC_FETCH:         seg_num = SEGN_W'(SEG_CODE);
        ACC_POP, ACC_PUSH: seg_num = SEGN_W'(SEG_STACK);
        default:           seg_num = SEGN_W'(SEG_DATA);
      endcase
    end
  end

  seg_selreg_file #(.NUM(NUM_SEGS)) u_sel (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (sr_we),
    .wnum (sr_num),
    .wval (sr_val),
    .rnum (seg_num),
    .rsel (cur_sel)
  );

  assign cur_idx = cur_sel[SEL_W-1:RING_W+1];

  // Table 0 is global, table 1 is local.
  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    localparam int DEP = (t == 0) ? G_DEPTH : L_DEPTH;
    seg_desc_table #(.DEPTH(DEP)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_req (dw_valid && (dw_local == t[0])),
      .wr_ring(dw_ring),
      .wr_idx (dw_index),
      .wr_data(wr_desc),
      .rd_idx (cur_idx),
      .rd_data(tab_rd[t]),
      .rd_hit (tab_hit[t])
    );
  end

  assign cur_desc = cur_sel[RING_W] ? tab_rd[1]  : tab_rd[0];
  assign cur_hit  = cur_sel[RING_W] ? tab_hit[1] : tab_hit[0];

  seg_check u_chk (
    .kind  (req_kind),
    .sel   (cur_sel),
    .desc  (cur_desc),
    .hit   (cur_hit),
    .offset(req_offset),
    .cpl   (req_cpl),
    .fault (chk_fault),
    .lin   (chk_lin)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_lin   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= chk_fault;
      rsp_lin   <= chk_lin;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dw_fault <= 1'b0;
    else        dw_fault <= dw_valid && (dw_ring != '0);
  end

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_lin)));

  assert_resp_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_lin == '0));

  assert_within_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chk_fault == FLT_NONE) |-> (cur_hit && req_offset <= cur_desc.limit));

  assert_null_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cur_sel[RING_W] && cur_idx == '0) |-> (chk_fault == FLT_NULL));

  assert_dw_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dw_fault) |-> $past(dw_valid));
endmodule

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GD = 16;
  localparam int LD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dw_valid = 0, dw_local = 0, dw_code = 0, dw_rw = 0;
  logic [1:0]  dw_ring = 0, dw_dpl = 0;
  logic [12:0] dw_index = 0;
  logic [31:0] dw_base = 0, dw_limit = 0;
  logic        dw_fault;
  logic        sr_we = 0;
  logic [2:0]  sr_num = 0;
  logic [15:0] sr_val = 0;
  logic        req_valid = 0, req_ovr_en = 0, rsp_ready = 1;
  logic        req_ready, rsp_valid;
  logic [2:0]  req_kind = 0, req_ovr_seg = 0;
  logic [31:0] req_offset = 0;
  logic [1:0]  req_cpl = 0;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_lin;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Model entry layout: {base, limit, code, rw, dpl}
  logic [67:0] gt [GD];
  logic [67:0] lt [LD];
  logic [15:0] selm [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .dw_valid(dw_valid), .dw_ring(dw_ring), .dw_local(dw_local), .dw_index(dw_index),
    .dw_base(dw_base), .dw_limit(dw_limit), .dw_code(dw_code), .dw_rw(dw_rw),
    .dw_dpl(dw_dpl), .dw_fault(dw_fault),
    .sr_we(sr_we), .sr_num(sr_num), .sr_val(sr_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg), .req_offset(req_offset),
    .req_cpl(req_cpl), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_lin(rsp_lin)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [33:0] model(input logic [2:0] kind, input logic oe,
                                        input logic [2:0] os, input logic [31:0] off,
                                        input logic [1:0] cpl);
    int sn;
    logic [15:0] s;
    logic [12:0] idx;
    logic [67:0] d;
    logic hit, nul, tbad, rbad, fet, sto;
    logic [1:0] f;
    if (oe) sn = (os > 3'd5) ? 1 : int'(os);
    else if (kind == 3'd0) sn = 0;
    else if (kind == 3'd3 || kind == 3'd4) sn = 2;
    else sn = 1;
    s = selm[sn];
    idx = s[15:3];
    if (s[2]) begin hit = idx < 13'(LD); d = hit ? lt[idx[2:0]] : '0; end
    else      begin hit = idx < 13'(GD); d = hit ? gt[idx[3:0]] : '0; end
    nul = !s[2] && idx == 0;
    fet = kind == 3'd0;
    sto = kind == 3'd2 || kind == 3'd4;
    if (d[3]) tbad = sto || (!fet && !d[2]);
    else      tbad = fet || (sto && !d[2]);
    rbad = !fet && (cpl > d[1:0] || s[1:0] > d[1:0]);
    if (nul) f = 2'd1;
    else if (!hit || off > d[35:4]) f = 2'd2;
    else if (tbad || rbad) f = 2'd3;
    else f = 2'd0;
    return {f, (f == 2'd0) ? d[67:36] + off : 32'd0};
  endfunction

  task automatic wdesc(input logic [1:0] ring, input logic loc, input int idx,
                       input logic [31:0] base, input logic [31:0] lim,
                       input logic code, input logic rw, input logic [1:0] dpl);
    @(negedge clk);
    dw_valid = 1; dw_ring = ring; dw_local = loc; dw_index = 13'(idx);
    dw_base = base; dw_limit = lim; dw_code = code; dw_rw = rw; dw_dpl = dpl;
    if (ring == 0) begin
      if (loc && idx < LD) lt[idx] = {base, lim, code, rw, dpl};
      if (!loc && idx < GD) gt[idx] = {base, lim, code, rw, dpl};
    end
    @(negedge clk);
    dw_valid = 0;
    chk(dw_fault == (ring != 0), "R8 dw_fault", 64'(dw_fault), 64'(ring != 0));
  endtask

  task automatic wsel(input int num, input logic [15:0] v);
    @(negedge clk);
    sr_we = 1; sr_num = 3'(num); sr_val = v;
    if (num < 6) selm[num] = v;
    @(negedge clk);
    sr_we = 0;
  endtask

  function automatic string tag_of(input logic [1:0] f);
    case (f)
      2'd0: return "R3 translate";
      2'd1: return "R1 null";
      2'd2: return "R4 limit";
      default: return "R5 R6 protection";
    endcase
  endfunction

  task automatic access(input logic [2:0] kind, input logic oe, input logic [2:0] os,
                        input logic [31:0] off, input logic [1:0] cpl, input string req);
    logic [33:0] e;
    e = model(kind, oe, os, off, cpl);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_ovr_en = oe; req_ovr_seg = os;
    req_offset = off; req_cpl = cpl; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && {rsp_fault, rsp_lin} == e,
        (req == "") ? tag_of(e[33:32]) : req,
        {29'd0, rsp_valid, rsp_fault, rsp_lin}, {29'd0, 1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [33:0] ea, eb;
    void'($urandom(32'h5eed));
    for (int i = 0; i < GD; i++) gt[i] = '0;
    for (int i = 0; i < LD; i++) lt[i] = '0;
    for (int i = 0; i < 6; i++) selm[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(rsp_valid == 0, "R10 rsp_valid", 64'(rsp_valid), 0);
    chk(dw_fault == 0, "R10 dw_fault", 64'(dw_fault), 0);
    chk(req_ready == 1, "R10 req_ready", 64'(req_ready), 1);
    access(3'd1, 0, 0, 32'h10, 0, "R10 zero selector is null");

    // Directed set-up
    wdesc(0, 0, 1, 32'h0, 32'hFFFF_FFFF, 1, 1, 0);   // flat code
    wdesc(0, 0, 2, 32'h1000, 32'hFF, 0, 1, 3);        // small writable data
    wdesc(0, 0, 3, 32'h20000, 32'hFFFF, 0, 0, 0);     // read-only data, ring 0
    wdesc(0, 1, 0, 32'h5000_0000, 32'h10, 0, 1, 3);   // local stack
    wdesc(0, 0, 4, 32'h300, 32'hFF, 1, 0, 0);         // execute-only code
    wsel(0, 16'h0008);
    wsel(1, 16'h0010);
    wsel(2, 16'h0004);
    wsel(3, 16'h0018);
    wsel(4, 16'h0000);
    wsel(5, 16'h00F8);                                 // global index 31

    access(3'd0, 0, 0, 32'h1234_5678, 0, "R3 flat pass-through");
    access(3'd1, 0, 0, 32'hFF, 3, "R3 R2 data read at limit");
    access(3'd1, 0, 0, 32'h100, 0, "R4 offset above limit");
    access(3'd4, 0, 0, 32'h10, 3, "R2 push uses stack, local index 0 not null R1");
    access(3'd3, 0, 0, 32'h11, 0, "R4 pop above stack limit");
    access(3'd2, 1, 3, 32'h8, 0, "R5 write to read-only data");
    access(3'd1, 1, 3, 32'h8, 1, "R6 ring above descriptor");
    access(3'd0, 1, 1, 32'h8, 0, "R5 fetch from data");
    access(3'd2, 1, 0, 32'h8, 0, "R5 write to code");
    access(3'd1, 1, 4, 32'h8, 0, "R1 null via extra register");
    access(3'd1, 1, 5, 32'h0, 0, "R4 index beyond global depth");
    access(3'd2, 1, 3, 32'h10000, 0, "R7 limit before type");
    access(3'd1, 1, 6, 32'h4, 0, "R2 override 6 maps to data");
    access(3'd0, 1, 3, 32'h4, 3, "R6 fetch not ring-checked but R5 type");
    wsel(3, 16'h0020);
    access(3'd1, 1, 3, 32'h4, 0, "R5 read of execute-only code");
    access(3'd0, 1, 3, 32'h4, 2, "R6 fetch ignores ring");
    wsel(3, 16'h001B);                                 // rpl 3 on ring-0 data
    access(3'd1, 1, 3, 32'h4, 0, "R6 selector ring above descriptor");
    wsel(6, 16'h0000);
    access(3'd1, 0, 0, 32'h20, 0, "R11 write to register 6 ignored");
    wdesc(1, 0, 2, 32'hDEAD_0000, 32'hFFFF_FFFF, 0, 1, 3);
    @(negedge clk);
    chk(dw_fault == 0, "R8 dw_fault one cycle", 64'(dw_fault), 0);
    access(3'd1, 0, 0, 32'h0, 0, "R8 ring 1 write ignored");
    wdesc(0, 0, 40, 32'hDEAD_0000, 32'hFFFF_FFFF, 0, 1, 3);
    access(3'd1, 0, 0, 32'h1, 0, "R8 out-of-depth write ignored");

    // R9 back-pressure
    ea = model(3'd1, 0, 0, 32'h10, 0);
    eb = model(3'd0, 0, 0, 32'h42, 0);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_kind = 3'd1; req_ovr_en = 0;
    req_offset = 32'h10; req_cpl = 0;
    @(negedge clk);
    req_kind = 3'd0; req_offset = 32'h42;
    chk(req_ready == 0, "R9 ready low while stalled", 64'(req_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && {rsp_fault, rsp_lin} == ea, "R9 held response",
          {rsp_valid, rsp_fault, rsp_lin}, {1'b1, ea});
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && {rsp_fault, rsp_lin} == eb, "R9 second response after release",
        {rsp_valid, rsp_fault, rsp_lin}, {1'b1, eb});
    @(negedge clk);
    chk(rsp_valid == 0, "R9 drained", 64'(rsp_valid), 0);

    // Constrained random
    for (int i = 0; i < GD; i++) begin
      int sel_l;
      logic [31:0] lim;
      sel_l = int'($urandom % 3);
      lim = (sel_l == 0) ? 32'hFFFF_FFFF : (sel_l == 1) ? ($urandom & 32'hFFFF) : 32'h0;
      wdesc(0, 0, i, $urandom, lim, 1'($urandom), 1'($urandom), 2'($urandom));
    end
    for (int i = 0; i < LD; i++)
      wdesc(0, 1, i, $urandom, $urandom & 32'hFFF, 1'($urandom), 1'($urandom), 2'($urandom));
    for (int r = 0; r < 10; r++) begin
      for (int s = 0; s < 6; s++) begin
        logic loc;
        int ix;
        loc = 1'($urandom);
        ix = int'($urandom % (loc ? 10 : 18));
        wsel(s, {13'(ix), loc, 2'($urandom)});
      end
      if (r % 3 == 1)
        wdesc(2'($urandom % 3) + 2'd1, 1'($urandom), int'($urandom % 8),
              $urandom, $urandom, 1'($urandom), 1'($urandom), 2'($urandom));
      for (int a = 0; a < 40; a++) begin
        logic [2:0] k, os;
        logic oe;
        logic [33:0] pk;
        logic [31:0] off;
        k = 3'($urandom % 6);
        oe = ($urandom % 4) == 0;
        os = 3'($urandom);
        pk = model(k, oe, os, 32'h0, 0);
        off = $urandom;
        if ($urandom % 2 == 0) off = off & 32'h1FFFF;
        access(k, oe, os, off, 2'($urandom), "");
        if (pk[33:32] == 2'd3) n_checks = n_checks;
      end
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule